// File: doc/BRIEF.md
# Network Controller Command and Status Register

This block is the host-facing command and status register of a descriptor-driven network controller. Software writes enables, loopback controls and a software reset through a 16-bit register port. The transmit and receive engines report finished frames, exhausted descriptor lists and bus errors as single-cycle pulses. The block combines the pending flags into one interrupt request line.

It also holds the starting address of each descriptor list. Each address is 32 bits wide and is written in two 16-bit halves. A write to the low half is only staged. A write to the high half publishes the full address to its engine, pulses that engine's load strobe for one cycle and clears that engine's list-exhausted flag. The engine then restarts from the new address.

Register selection, with `reg_addr`: 0 command/status, 1 receive list low half, 2 receive list high half, 3 transmit list low half, 4 transmit list high half. Reads are combinational on `reg_addr`.

Top module: `nic_csr`

## Requirements
- R1: After `rst_n` is released, the command/status word reads 0x0030, `irq`, `soft_rst`, both load strobes and all three enable outputs are 0, and both list addresses are 0.
- R2: Command/status bits 0 (`rx_en`), 6 (interrupt enable), 8 (`iloop_dis`) and 9 (`eloop_en`) are read/write. Bits 0, 8 and 9 drive the outputs of the same names from the cycle after the write.
- R3: Bits 3 and 10 to 14 of the command/status word always read 0, whatever is written to them.
- R4: A `tx_done` pulse sets bit 7 and an `rx_done` pulse sets bit 15. Each flag stays set until a command/status write has a 1 in that bit position. A 0 written there leaves the flag unchanged.
- R5: A `bus_err` pulse sets bit 2. The flag stays set until a command/status write has a 1 in bit 2.
- R6: When an event pulse and a write that would clear the matching flag fall in the same cycle, the flag ends up set. This holds for bits 2, 4, 5, 7 and 15.
- R7: `irq` is high exactly when bit 6 is set and at least one of bits 7 and 15 is set.
- R8: A command/status write with bit 1 at 0, made while bit 1 holds 1, has two effects. First, `soft_rst` is high for exactly the next cycle. Second, the word returns to 0x0030, and the other bits of that write are ignored. A write with bit 1 at 0 while bit 1 already holds 0 gives no pulse. List addresses are not affected by the software reset.
- R9: Bit 4 (transmit list exhausted) is set by a `tx_empty` pulse and bit 5 (receive list exhausted) by an `rx_empty` pulse. Command/status writes never change them.
- R10: A write at `reg_addr` 1 or 3 stages the low half without changing the list address outputs. A write at 2 or 4 loads {written data, staged low half} onto `rx_list_addr` or `tx_list_addr`. It also raises that engine's load strobe for the next cycle only and clears bit 5 or bit 4 respectively.
- R11: Reads at `reg_addr` 1 to 4 return the staged low half or the loaded high half of the matching address. Reads at addresses 5 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| tx_done | input | 1 | Transmit frame finished pulse |
| rx_done | input | 1 | Receive frame finished pulse |
| tx_empty | input | 1 | Transmit descriptor list exhausted pulse |
| rx_empty | input | 1 | Receive descriptor list exhausted pulse |
| bus_err | input | 1 | Access to non-existent memory pulse |
| irq | output | 1 | Interrupt request |
| soft_rst | output | 1 | One-cycle controller reset pulse |
| rx_en | output | 1 | Receiver enable |
| iloop_dis | output | 1 | Internal loopback disable |
| eloop_en | output | 1 | External loopback enable |
| rx_list_addr | output | 32 | Receive list start address |
| rx_list_load | output | 1 | Receive list restart strobe |
| tx_list_addr | output | 32 | Transmit list start address |
| tx_list_load | output | 1 | Transmit list restart strobe |

## Verification
The properties assume that the event inputs are single-cycle pulses sampled on the rising edge, and that `reg_addr` and `reg_wdata` hold steady while `reg_wr` is high.

The stimulus drives every input on the falling edge and returns each event to 0 in the following step. Events coincide with writes only where the same-cycle priority of R6 is being exercised. The software reset is triggered only by writing 1 and then 0 to bit 1, and it is never paired with an event in the same cycle.

// File: rtl/nic_csr.sv
module nic_csr (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        tx_done,
  input  logic        rx_done,
  input  logic        tx_empty,
  input  logic        rx_empty,
  input  logic        bus_err,
  output logic        irq,
  output logic        soft_rst,
  output logic        rx_en,
  output logic        iloop_dis,
  output logic        eloop_en,
  output logic [31:0] rx_list_addr,
  output logic        rx_list_load,
  output logic [31:0] tx_list_addr,
  output logic        tx_list_load
);
  localparam logic [2:0] A_CSR  = 3'd0;
  localparam logic [2:0] A_RXLO = 3'd1;
  localparam logic [2:0] A_RXHI = 3'd2;
  localparam logic [2:0] A_TXLO = 3'd3;
  localparam logic [2:0] A_TXHI = 3'd4;

  logic rx_en_q, rst_bit_q, nxm_q, txe_q, rxe_q, ie_q, txi_q, iloop_q, eloop_q, rxi_q;
  logic soft_rst_q, rx_load_q, tx_load_q;
  logic [15:0] rx_lo_q, tx_lo_q;
  logic [31:0] rx_addr_q, tx_addr_q;
  logic [15:0] csr;

  wire wr_csr  = reg_wr && (reg_addr == A_CSR);
  wire wr_rxhi = reg_wr && (reg_addr == A_RXHI);
  wire wr_txhi = reg_wr && (reg_addr == A_TXHI);
  wire do_rst  = wr_csr && rst_bit_q && !reg_wdata[1];

  assign csr = {rxi_q, 5'b0, eloop_q, iloop_q, txi_q, ie_q, rxe_q, txe_q,
                1'b0, nxm_q, rst_bit_q, rx_en_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {rx_en_q, rst_bit_q, nxm_q, ie_q, txi_q, iloop_q, eloop_q, rxi_q} <= '0;
      txe_q      <= 1'b1;
      rxe_q      <= 1'b1;
      soft_rst_q <= 1'b0;
    end else begin
      soft_rst_q <= do_rst;
      if (do_rst) begin
        {rx_en_q, rst_bit_q, nxm_q, ie_q, txi_q, iloop_q, eloop_q, rxi_q} <= '0;
        txe_q <= 1'b1;
        rxe_q <= 1'b1;
      end else begin
        if (wr_csr) begin
          rx_en_q   <= reg_wdata[0];
          rst_bit_q <= reg_wdata[1];
          ie_q      <= reg_wdata[6];
          iloop_q   <= reg_wdata[8];
          eloop_q   <= reg_wdata[9];
        end
        txi_q <= tx_done | (txi_q & ~(wr_csr & reg_wdata[7]));
        rxi_q <= rx_done | (rxi_q & ~(wr_csr & reg_wdata[15]));
        nxm_q <= bus_err | (nxm_q & ~(wr_csr & reg_wdata[2]));
        txe_q <= tx_empty | (txe_q & ~wr_txhi);
        rxe_q <= rx_empty | (rxe_q & ~wr_rxhi);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_lo_q   <= '0;
      tx_lo_q   <= '0;
      rx_addr_q <= '0;
      tx_addr_q <= '0;
      rx_load_q <= 1'b0;
      tx_load_q <= 1'b0;
    end else begin
      rx_load_q <= wr_rxhi;
      tx_load_q <= wr_txhi;
      if (reg_wr && reg_addr == A_RXLO) rx_lo_q <= reg_wdata;
      if (reg_wr && reg_addr == A_TXLO) tx_lo_q <= reg_wdata;
      if (wr_rxhi) rx_addr_q <= {reg_wdata, rx_lo_q};
      if (wr_txhi) tx_addr_q <= {reg_wdata, tx_lo_q};
    end
  end

  always_comb begin
    case (reg_addr)
      A_CSR:   reg_rdata = csr;
      A_RXLO:  reg_rdata = rx_lo_q;
      A_RXHI:  reg_rdata = rx_addr_q[31:16];
      A_TXLO:  reg_rdata = tx_lo_q;
      A_TXHI:  reg_rdata = tx_addr_q[31:16];
      default: reg_rdata = '0;
    endcase
  end

  assign irq          = ie_q & (txi_q | rxi_q);
  assign soft_rst     = soft_rst_q;
  assign rx_en        = rx_en_q;
  assign iloop_dis    = iloop_q;
  assign eloop_en     = eloop_q;
  assign rx_list_addr = rx_addr_q;
  assign tx_list_addr = tx_addr_q;
  assign rx_list_load = rx_load_q;
  assign tx_list_load = tx_load_q;
endmodule

// File: rtl/nic_csr_checker.sv
module nic_csr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [2:0]  reg_addr,
  input logic [15:0] reg_wdata,
  input logic        tx_done,
  input logic        rx_done,
  input logic        bus_err,
  input logic        irq,
  input logic        soft_rst,
  input logic        rx_en,
  input logic        rx_list_load,
  input logic        tx_list_load,
  input logic [15:0] csr
);
  assert_rst_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !soft_rst);

  assert_rst_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> (!rx_en && !irq && csr == 16'h0030));

  assert_tx_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tx_done) && !soft_rst) |-> csr[7]);

  assert_rx_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rx_done) && !soft_rst) |-> csr[15]);

  assert_nxm_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(csr[2]) && !($past(reg_wr) && $past(reg_addr) == 3'd0 && $past(reg_wdata[2]))
     && !soft_rst) |-> csr[2]);

  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (csr[14:10] == 5'd0 && !csr[3]));

  assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (csr[6] && (csr[7] || csr[15])));

  assert_rx_load_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_list_load |-> ($past(reg_wr) && $past(reg_addr) == 3'd2));

  assert_tx_load_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_list_load |-> ($past(reg_wr) && $past(reg_addr) == 3'd4));
endmodule

bind nic_csr nic_csr_checker chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .tx_done(tx_done), .rx_done(rx_done),
  .bus_err(bus_err), .irq(irq), .soft_rst(soft_rst), .rx_en(rx_en),
  .rx_list_load(rx_list_load), .tx_list_load(tx_list_load), .csr(csr)
);

// File: tb/nic_csr_tb.sv
module nic_csr_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic tx_done = 0, rx_done = 0, tx_empty = 0, rx_empty = 0, bus_err = 0;
  logic irq, soft_rst, rx_en, iloop_dis, eloop_en, rx_list_load, tx_list_load;
  logic [31:0] rx_list_addr, tx_list_addr;

  always #4 clk = ~clk;

  nic_csr dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_done(tx_done),
    .rx_done(rx_done), .tx_empty(tx_empty), .rx_empty(rx_empty),
    .bus_err(bus_err), .irq(irq), .soft_rst(soft_rst), .rx_en(rx_en),
    .iloop_dis(iloop_dis), .eloop_en(eloop_en), .rx_list_addr(rx_list_addr),
    .rx_list_load(rx_list_load), .tx_list_addr(tx_list_addr),
    .tx_list_load(tx_list_load)
  );

  localparam int S_RDATA = 0, S_IRQ = 1, S_SRST = 2, S_RXLD = 3,
                 S_TXLD = 4, S_RXA = 5, S_TXA = 6, S_ENS = 7;

  typedef struct {
    int          sig;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t sb[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic step(input bit wr, input logic [2:0] a, input logic [15:0] d,
                      input logic [4:0] ev);
    @(negedge clk);
    reg_wr    = wr;
    reg_addr  = a;
    reg_wdata = d;
    {bus_err, rx_empty, tx_empty, rx_done, tx_done} = ev;
  endtask

  task automatic expect_sig(input int sig, input logic [31:0] v, input string req);
    item_t it;
    it.sig = sig;
    it.exp = v;
    it.req = req;
    sb.push_back(it);
  endtask

  task automatic expect_csr(input logic [15:0] v, input string req);
    expect_sig(S_RDATA, {16'h0, v}, req);
  endtask

  always @(posedge clk) begin
    #2;
    while (sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      case (it.sig)
        S_RDATA: act = {16'h0, reg_rdata};
        S_IRQ:   act = {31'h0, irq};
        S_SRST:  act = {31'h0, soft_rst};
        S_RXLD:  act = {31'h0, rx_list_load};
        S_TXLD:  act = {31'h0, tx_list_load};
        S_RXA:   act = rx_list_addr;
        S_TXA:   act = tx_list_addr;
        default: act = {29'h0, eloop_en, iloop_dis, rx_en};
      endcase
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s sig=%0d actual=%h expected=%h", it.req, it.sig, act, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    step(0, 3'd0, 16'h0, 5'b0);
    expect_csr(16'h0030, "R1");
    expect_sig(S_IRQ, 0, "R1");
    expect_sig(S_SRST, 0, "R1");
    expect_sig(S_RXLD, 0, "R1");
    expect_sig(S_TXLD, 0, "R1");
    expect_sig(S_RXA, 0, "R1");
    expect_sig(S_TXA, 0, "R1");
    expect_sig(S_ENS, 0, "R1");

    step(1, 3'd0, 16'hFFFF, 5'b0);
    expect_csr(16'h0373, "R2 R3 R9");
    expect_sig(S_ENS, 3'b111, "R2");
    expect_sig(S_SRST, 0, "R8");

    step(1, 3'd0, 16'h0000, 5'b0);
    expect_csr(16'h0030, "R8");
    expect_sig(S_SRST, 1, "R8");
    expect_sig(S_ENS, 0, "R8");
    step(0, 3'd0, 16'h0, 5'b0);
    expect_sig(S_SRST, 0, "R8");
    step(1, 3'd0, 16'h0000, 5'b0);
    expect_sig(S_SRST, 0, "R8");

    step(1, 3'd0, 16'h0041, 5'b0);
    expect_csr(16'h0071, "R2");
    expect_sig(S_IRQ, 0, "R7");
    step(0, 3'd0, 16'h0, 5'b00001);
    expect_csr(16'h00F1, "R4");
    expect_sig(S_IRQ, 1, "R7");
    step(1, 3'd0, 16'h0041, 5'b0);
    expect_csr(16'h00F1, "R4");
    step(0, 3'd0, 16'h0, 5'b00010);
    expect_csr(16'h80F1, "R4");
    step(1, 3'd0, 16'h00C1, 5'b0);
    expect_csr(16'h8071, "R4");
    expect_sig(S_IRQ, 1, "R7");
    step(1, 3'd0, 16'h8041, 5'b0);
    expect_csr(16'h0071, "R4");
    expect_sig(S_IRQ, 0, "R7");

    step(1, 3'd0, 16'h0001, 5'b0);
    step(0, 3'd0, 16'h0, 5'b00001);
    expect_csr(16'h00B1, "R7");
    expect_sig(S_IRQ, 0, "R7");
    step(1, 3'd0, 16'h0041, 5'b0);
    expect_sig(S_IRQ, 1, "R7");
    step(1, 3'd0, 16'h00C1, 5'b0);
    expect_csr(16'h0071, "R4");

    step(0, 3'd0, 16'h0, 5'b10000);
    expect_csr(16'h0075, "R5");
    step(0, 3'd0, 16'h0, 5'b0);
    expect_csr(16'h0075, "R5");
    step(1, 3'd0, 16'h0041, 5'b0);
    expect_csr(16'h0075, "R5");
    step(1, 3'd0, 16'h0045, 5'b0);
    expect_csr(16'h0071, "R5");

    step(1, 3'd0, 16'h80C5, 5'b10011);
    expect_csr(16'h80F5, "R6");
    step(1, 3'd0, 16'h80C5, 5'b0);
    expect_csr(16'h0071, "R6");

    step(1, 3'd1, 16'h1234, 5'b0);
    expect_sig(S_RXA, 0, "R10");
    expect_sig(S_RXLD, 0, "R10");
    step(1, 3'd2, 16'hABCD, 5'b0);
    expect_sig(S_RXA, 32'hABCD1234, "R10");
    expect_sig(S_RXLD, 1, "R10");
    step(0, 3'd0, 16'h0, 5'b0);
    expect_csr(16'h0051, "R10");
    expect_sig(S_RXLD, 0, "R10");
    step(0, 3'd1, 16'h0, 5'b0);
    expect_csr(16'h1234, "R11");
    step(0, 3'd2, 16'h0, 5'b0);
    expect_csr(16'hABCD, "R11");
    step(1, 3'd3, 16'h5678, 5'b0);
    step(1, 3'd4, 16'h9ABC, 5'b0);
    expect_sig(S_TXA, 32'h9ABC5678, "R10");
    expect_sig(S_TXLD, 1, "R10");
    expect_sig(S_RXLD, 0, "R10");
    step(0, 3'd0, 16'h0, 5'b0);
    expect_csr(16'h0041, "R10");
    expect_sig(S_TXLD, 0, "R10");
    step(0, 3'd3, 16'h0, 5'b0);
    expect_csr(16'h5678, "R11");

    step(0, 3'd0, 16'h0, 5'b00100);
    expect_csr(16'h0051, "R9");
    step(1, 3'd0, 16'h0041, 5'b0);
    expect_csr(16'h0051, "R9");
    step(1, 3'd4, 16'h9ABC, 5'b00100);
    expect_sig(S_TXLD, 1, "R6");
    step(0, 3'd0, 16'h0, 5'b01000);
    expect_csr(16'h0071, "R6 R9");

    step(0, 3'd5, 16'h0, 5'b0);
    expect_csr(16'h0000, "R11");
    step(0, 3'd7, 16'h0, 5'b0);
    expect_csr(16'h0000, "R11");

    step(1, 3'd0, 16'h0343, 5'b0);
    expect_sig(S_ENS, 3'b111, "R2");
    step(1, 3'd0, 16'h0341, 5'b0);
    expect_csr(16'h0030, "R8");
    expect_sig(S_SRST, 1, "R8");
    expect_sig(S_RXA, 32'hABCD1234, "R8");
    expect_sig(S_TXA, 32'h9ABC5678, "R8");

    step(0, 3'd0, 16'h0, 5'b0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule